// File: doc/BRIEF.md
# Transactional Line Access Monitor

This block sits beside a core's first-level cache and keeps a small record of the cache lines that the running transaction has touched. Each record is one line-tagged entry. It holds a read flag, a write flag, two watch flags and a bitmap of the 8-byte word positions that were accessed transactionally within the line. Local accesses from the core add to the record. Remote snoop requests from other cores are compared against it.

A remote access that collides with the record wins against the local transaction. The block then raises a conflict-abort request. It also reports three local problems: running out of entries (capacity abort), a non-transactional store to a line written transactionally (general-protection fault), and a release whose line holds more than one accessed word (release fault). A separate transaction controller opens the transaction and ends it with a commit or discard strobe. All outputs are single-cycle pulses registered one clock after the request that causes them.

Top module: `tlm_monitor`

## Requirements
- R1: After reset all four outputs are low, and no line is tracked, so a remote write to any address raises no conflict.
- R2: Lines are 64 bytes. `locOp` encodes 0 = load, 1 = store, 2 = release, 3 = watch-read, 4 = watch-write. Two addresses that differ only in bits [5:0] refer to the same entry, and addresses in different lines never match.
- R3: While a transaction is open, a remote write to a line with any flag set, or a remote read of a line with the write or watch-write flag set, pulses `conflictAbort` in the next cycle. A remote read of a line that was only read raises nothing.
- R4: A watch-read entry conflicts with a remote write but not with a remote read. A watch-write entry conflicts with both.
- R5: Four distinct lines can be tracked at once. A transactional load, transactional store or watch to a fifth line, with no free entry, pulses `capacityAbort` in the next cycle and leaves every entry unchanged. An access that hits a tracked line never raises it.
- R6: A release on a tracked, unwritten line whose bitmap has at most one word position clears that line's read tracking. Later remote writes to the line no longer conflict. The entry is freed if the line carries no watch flag.
- R7: A release on a line written transactionally is ignored: there is no pulse, and the line stays tracked.
- R8: Word positions are address bits [5:3]. A release on an unwritten line whose bitmap holds two or more positions pulses `relFault` and keeps the tracking. Two accesses to the same 8-byte word count as one position.
- R9: A non-transactional store to a line written transactionally pulses `gpFault`. Non-transactional loads and stores are otherwise allowed, raise nothing and allocate no entry.
- R10: A commit or discard strobe clears all entries in that cycle. A local access or snoop in the same cycle is ignored.
- R11: While `txnOpen` is low, snoops raise no conflict and local accesses are not tracked.
- R12: A snoop is judged against the entries as they were before the local access of the same cycle updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txnOpen | input | 1 | A transaction is open |
| commitStrobe | input | 1 | Transaction committed; clear all entries |
| discardStrobe | input | 1 | Transaction discarded; clear all entries |
| locValid | input | 1 | Local access request valid |
| locOp | input | 3 | Local operation code (see R2) |
| locTxn | input | 1 | Load or store is transactional |
| locAddr | input | ADDR_W | Local byte address |
| snpValid | input | 1 | Remote snoop valid |
| snpWrite | input | 1 | Remote snoop is a store |
| snpAddr | input | ADDR_W | Remote snoop byte address |
| conflictAbort | output | 1 | Abort request: remote conflict |
| capacityAbort | output | 1 | Abort request: no free entry |
| gpFault | output | 1 | Non-transactional store to a transactionally written line |
| relFault | output | 1 | Release on a line with several accessed words |

## Verification
Two functions can fall in the same cycle: the update of an entry by a local access, and the conflict check of a remote snoop. The bench drives a transactional store and a remote read to the same, previously untracked line in one cycle and expects no conflict. A remote read one cycle later must then abort. It also puts a commit strobe in the same cycle as a transactional load and checks, with a later remote write, that the load left no trace.

// File: rtl/tlm_pkg.sv
package tlm_pkg;

  typedef enum logic [2:0] {
    OP_LOAD     = 3'd0,
    OP_STORE    = 3'd1,
    OP_RELEASE  = 3'd2,
    OP_WATCH_RD = 3'd3,
    OP_WATCH_WR = 3'd4
  } accOp_e;

  // strobes from control to the entry array
  typedef struct packed {
    logic setRd;
    logic setWr;
    logic setWatchRd;
    logic setWatchWr;
    logic markWord;
    logic dropRead;
    logic clearAll;
  } entryCmd_t;

  // lookup results from the entry array back to control
  typedef struct packed {
    logic anyHit;
    logic anyFree;
    logic hitWr;
    logic hitMultiWord;
    logic snpConflict;
  } lookup_t;

endpackage

// File: rtl/tlm_datapath.sv
module tlm_datapath
  import tlm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ENTRIES  = 4,
  parameter int LINE_LSB = 6,
  parameter int WORD_LSB = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic              snpValid,
  input  logic              snpWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  input  entryCmd_t         cmd,
  output lookup_t           lookup
);

  localparam int TAG_W = ADDR_W - LINE_LSB;
  localparam int OFS_W = LINE_LSB - WORD_LSB;
  localparam int WORDS = 1 << OFS_W;

  logic [ENTRIES-1:0] validQ, rdQ, wrQ, watchRdQ, watchWrQ;
  logic [TAG_W-1:0]   tagQ  [ENTRIES];
  logic [WORDS-1:0]   wordQ [ENTRIES];

  logic [TAG_W-1:0] locTag, snpTag;
  logic [WORDS-1:0] wordSel;
  logic [ENTRIES-1:0] locHit, snpConf, multiWord, freeVec, selVec;
  logic grow;
  logic unusedLowBits;

  assign locTag  = locAddr[ADDR_W-1:LINE_LSB];
  assign snpTag  = snpAddr[ADDR_W-1:LINE_LSB];
  assign wordSel = WORDS'(1) << locAddr[LINE_LSB-1:WORD_LSB];
  assign unusedLowBits = ^{locAddr[WORD_LSB-1:0], snpAddr[LINE_LSB-1:0]};

  // per-entry tag match and conflict rule
  for (genvar e = 0; e < ENTRIES; e++) begin : g_match
    logic snpHit;
    assign locHit[e]    = validQ[e] && (tagQ[e] == locTag);
    assign snpHit       = validQ[e] && (tagQ[e] == snpTag);
    assign snpConf[e]   = snpHit && (snpWrite ? (rdQ[e] | wrQ[e] | watchRdQ[e] | watchWrQ[e])
                                              : (wrQ[e] | watchWrQ[e]));
    assign multiWord[e] = $countones(wordQ[e]) > 1;
  end

  // lowest free entry
  always_comb begin
    freeVec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!validQ[i] && (freeVec == '0)) freeVec[i] = 1'b1;
    end
  end

  assign selVec = (|locHit) ? locHit : freeVec;
  assign grow   = cmd.setRd | cmd.setWr | cmd.setWatchRd | cmd.setWatchWr;

  always_comb begin
    lookup.anyHit       = |locHit;
    lookup.anyFree      = |freeVec;
    lookup.hitWr        = |(locHit & wrQ);
    lookup.hitMultiWord = |(locHit & multiWord);
    lookup.snpConflict  = snpValid && (|snpConf);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0; rdQ <= '0; wrQ <= '0; watchRdQ <= '0; watchWrQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i]  <= '0;
        wordQ[i] <= '0;
      end
    end else if (cmd.clearAll) begin
      validQ <= '0; rdQ <= '0; wrQ <= '0; watchRdQ <= '0; watchWrQ <= '0;
      for (int i = 0; i < ENTRIES; i++) wordQ[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (selVec[i] && grow) begin
          validQ[i]   <= 1'b1;
          tagQ[i]     <= locTag;
          rdQ[i]      <= (validQ[i] & rdQ[i])      | cmd.setRd;
          wrQ[i]      <= (validQ[i] & wrQ[i])      | cmd.setWr;
          watchRdQ[i] <= (validQ[i] & watchRdQ[i]) | cmd.setWatchRd;
          watchWrQ[i] <= (validQ[i] & watchWrQ[i]) | cmd.setWatchWr;
          wordQ[i]    <= (validQ[i] ? wordQ[i] : '0) | (cmd.markWord ? wordSel : '0);
        end else if (selVec[i] && cmd.dropRead) begin
          rdQ[i]   <= 1'b0;
          wordQ[i] <= '0;
          if (!watchRdQ[i] && !watchWrQ[i]) validQ[i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/tlm_ctrl.sv
module tlm_ctrl
  import tlm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txnOpen,
  input  logic      commitStrobe,
  input  logic      discardStrobe,
  input  logic      locValid,
  input  logic [2:0] locOp,
  input  logic      locTxn,
  input  lookup_t   lookup,
  output entryCmd_t cmd,
  output logic      conflictAbort,
  output logic      capacityAbort,
  output logic      gpFault,
  output logic      relFault
);

  logic active, memOp;
  logic txnLd, txnSt, watchRd, watchWr, wantLine, capMiss, relOk;
  logic conflictNext, gpNext, relNext;

  assign active   = txnOpen && !commitStrobe && !discardStrobe;
  assign memOp    = locValid && active;
  assign txnLd    = memOp && locTxn && (locOp == OP_LOAD);
  assign txnSt    = memOp && locTxn && (locOp == OP_STORE);
  assign watchRd  = memOp && (locOp == OP_WATCH_RD);
  assign watchWr  = memOp && (locOp == OP_WATCH_WR);
  assign wantLine = txnLd | txnSt | watchRd | watchWr;
  assign capMiss  = wantLine && !lookup.anyHit && !lookup.anyFree;
  assign relOk    = memOp && (locOp == OP_RELEASE) && lookup.anyHit && !lookup.hitWr;

  assign conflictNext = active && lookup.snpConflict;
  assign gpNext       = memOp && !locTxn && (locOp == OP_STORE) && lookup.anyHit && lookup.hitWr;
  assign relNext      = relOk && lookup.hitMultiWord;

  always_comb begin
    cmd.setRd      = txnLd && !capMiss;
    cmd.setWr      = txnSt && !capMiss;
    cmd.setWatchRd = watchRd && !capMiss;
    cmd.setWatchWr = watchWr && !capMiss;
    cmd.markWord   = (txnLd | txnSt) && !capMiss;
    cmd.dropRead   = relOk && !lookup.hitMultiWord;
    cmd.clearAll   = commitStrobe | discardStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      conflictAbort <= 1'b0;
      capacityAbort <= 1'b0;
      gpFault       <= 1'b0;
      relFault      <= 1'b0;
    end else begin
      conflictAbort <= conflictNext;
      capacityAbort <= capMiss;
      gpFault       <= gpNext;
      relFault      <= relNext;
    end
  end

endmodule

// File: rtl/tlm_monitor.sv
module tlm_monitor
  import tlm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ENTRIES  = 4,
  parameter int LINE_LSB = 6,
  parameter int WORD_LSB = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnOpen,
  input  logic              commitStrobe,
  input  logic              discardStrobe,
  input  logic              locValid,
  input  logic [2:0]        locOp,
  input  logic              locTxn,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic              snpValid,
  input  logic              snpWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              conflictAbort,
  output logic              capacityAbort,
  output logic              gpFault,
  output logic              relFault
);

  entryCmd_t cmd;
  lookup_t   lookup;

  tlm_datapath #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .LINE_LSB(LINE_LSB), .WORD_LSB(WORD_LSB)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .locAddr(locAddr),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpAddr(snpAddr),
    .cmd(cmd), .lookup(lookup)
  );

  tlm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .txnOpen(txnOpen),
    .commitStrobe(commitStrobe), .discardStrobe(discardStrobe),
    .locValid(locValid), .locOp(locOp), .locTxn(locTxn),
    .lookup(lookup), .cmd(cmd),
    .conflictAbort(conflictAbort), .capacityAbort(capacityAbort),
    .gpFault(gpFault), .relFault(relFault)
  );

endmodule

// File: rtl/tlm_monitor_chk.sv
module tlm_monitor_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txnOpen,
  input logic       commitStrobe,
  input logic       discardStrobe,
  input logic       locValid,
  input logic [2:0] locOp,
  input logic       locTxn,
  input logic       snpValid,
  input logic       conflictAbort,
  input logic       capacityAbort,
  input logic       gpFault,
  input logic       relFault
);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rstN |=> (!conflictAbort && !capacityAbort && !gpFault && !relFault));

  a_r3_conflict_needs_snoop: assert property (@(posedge clk) disable iff (!rstN)
    conflictAbort |-> $past(snpValid));

  a_r5_capacity_needs_alloc: assert property (@(posedge clk) disable iff (!rstN)
    capacityAbort |-> $past(locValid && locOp != 3'd2 && txnOpen));

  a_r5_local_faults_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({capacityAbort, gpFault, relFault}));

  a_r8_relfault_needs_release: assert property (@(posedge clk) disable iff (!rstN)
    relFault |-> $past(locValid && locOp == 3'd2));

  a_r9_gp_needs_plain_store: assert property (@(posedge clk) disable iff (!rstN)
    gpFault |-> $past(locValid && locOp == 3'd1 && !locTxn));

  a_r10_strobe_silences: assert property (@(posedge clk) disable iff (!rstN)
    (commitStrobe || discardStrobe) |=>
      (!conflictAbort && !capacityAbort && !gpFault && !relFault));

  a_r11_closed_is_silent: assert property (@(posedge clk) disable iff (!rstN)
    !txnOpen |=> (!conflictAbort && !capacityAbort));

endmodule

bind tlm_monitor tlm_monitor_chk chk_i (
  .clk(clk), .rstN(rstN), .txnOpen(txnOpen),
  .commitStrobe(commitStrobe), .discardStrobe(discardStrobe),
  .locValid(locValid), .locOp(locOp), .locTxn(locTxn), .snpValid(snpValid),
  .conflictAbort(conflictAbort), .capacityAbort(capacityAbort),
  .gpFault(gpFault), .relFault(relFault)
);

// File: tb/tlm_monitor_tb_top.sv
`timescale 1ns/1ps
module tlm_monitor_tb_top;

  localparam logic [2:0] LD = 3'd0, ST = 3'd1, REL = 3'd2, WRD = 3'd3, WWR = 3'd4;
  localparam logic [31:0] LA = 32'h1000, LB = 32'h2000, LC = 32'h3000,
                          LDD = 32'h4000, LE = 32'h5000;
  // expected vector bit order: {conflict, capacity, gp, release}
  localparam logic [3:0] NONE = 4'b0000, CONF = 4'b1000, CAP = 4'b0100,
                         GP = 4'b0010, RELF = 4'b0001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txnOpen = 1'b0, commitStrobe = 1'b0, discardStrobe = 1'b0;
  logic locValid = 1'b0, locTxn = 1'b0, snpValid = 1'b0, snpWrite = 1'b0;
  logic [2:0]  locOp = 3'd0;
  logic [31:0] locAddr = '0, snpAddr = '0;
  logic conflictAbort, capacityAbort, gpFault, relFault;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    logic [3:0] exp;
    string      req;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  tlm_monitor dut_i (
    .clk(clk), .rstN(rstN), .txnOpen(txnOpen),
    .commitStrobe(commitStrobe), .discardStrobe(discardStrobe),
    .locValid(locValid), .locOp(locOp), .locTxn(locTxn), .locAddr(locAddr),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpAddr(snpAddr),
    .conflictAbort(conflictAbort), .capacityAbort(capacityAbort),
    .gpFault(gpFault), .relFault(relFault)
  );

  function automatic void compare(input logic [3:0] exp, input string req);
    logic [3:0] act;
    act = {conflictAbort, capacityAbort, gpFault, relFault};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: outputs {conf,cap,gp,rel} actual=%b expected=%b", req, act, exp);
    end
  endfunction

  // monitor: one expected item per driven cycle, compared after the edge
  initial begin
    forever begin
      item_t it;
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        compare(it.exp, it.req);
      end
    end
  end

  task automatic step(input logic lv, input logic [2:0] op, input logic tx,
                      input logic [31:0] la, input logic sv, input logic sw,
                      input logic [31:0] sa, input logic cm, input logic ds,
                      input logic [3:0] exp, input string req);
    item_t it;
    @(negedge clk);
    locValid = lv; locOp = op; locTxn = tx; locAddr = la;
    snpValid = sv; snpWrite = sw; snpAddr = sa;
    commitStrobe = cm; discardStrobe = ds;
    it.exp = exp;
    it.req = req;
    sbq.push_back(it);
  endtask

  task automatic loc(input logic [2:0] op, input logic tx, input logic [31:0] a,
                     input logic [3:0] exp, input string req);
    step(1'b1, op, tx, a, 1'b0, 1'b0, '0, 1'b0, 1'b0, exp, req);
  endtask

  task automatic snp(input logic w, input logic [31:0] a,
                     input logic [3:0] exp, input string req);
    step(1'b0, LD, 1'b0, '0, 1'b1, w, a, 1'b0, 1'b0, exp, req);
  endtask

  task automatic discard(input string req);
    step(1'b0, LD, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1, NONE, req);
  endtask

  task automatic setTxn(input logic v);
    @(negedge clk);
    locValid = 1'b0; snpValid = 1'b0; commitStrobe = 1'b0; discardStrobe = 1'b0;
    txnOpen = v;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compare(NONE, "R1 reset outputs");
    setTxn(1'b1);
    snp(1'b1, LA, NONE, "R1 nothing tracked after reset");

    // line granularity and basic conflicts
    loc(LD, 1'b1, LA + 32'h08, NONE, "R2 txn load");
    snp(1'b1, LA + 32'h30, CONF, "R2 R3 remote write same line other word");
    snp(1'b0, LA, NONE, "R3 remote read vs read-only line");
    snp(1'b1, LA + 32'h40, NONE, "R2 neighbouring line no match");
    step(1'b0, LD, 1'b0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b0, NONE, "R10 commit");
    snp(1'b1, LA, NONE, "R10 entries cleared by commit");

    loc(ST, 1'b1, LB, NONE, "R3 txn store");
    snp(1'b0, LB + 32'h10, CONF, "R3 remote read vs written line");
    loc(ST, 1'b0, LB + 32'h08, GP, "R9 plain store to written line");
    loc(LD, 1'b0, LB, NONE, "R9 plain load allowed");
    loc(ST, 1'b0, LC, NONE, "R9 plain store to untracked line");
    snp(1'b1, LC, NONE, "R9 plain access not tracked");
    discard("R10 discard");
    snp(1'b0, LB, NONE, "R10 entries cleared by discard");

    // watches
    loc(WRD, 1'b0, LC, NONE, "R4 watch-read set");
    snp(1'b0, LC, NONE, "R4 watch-read ignores remote read");
    snp(1'b1, LC + 32'h18, CONF, "R4 watch-read aborts on remote write");
    loc(WWR, 1'b0, LDD, NONE, "R4 watch-write set");
    snp(1'b0, LDD, CONF, "R4 watch-write aborts on remote read");
    discard("R10 discard");

    // capacity
    loc(LD, 1'b1, LA, NONE, "R5 fill 1");
    loc(LD, 1'b1, LB, NONE, "R5 fill 2");
    loc(LD, 1'b1, LC, NONE, "R5 fill 3");
    loc(LD, 1'b1, LDD, NONE, "R5 fill 4");
    loc(LD, 1'b1, LE, CAP, "R5 fifth line overflows");
    snp(1'b1, LE, NONE, "R5 overflowing line not tracked");
    loc(LD, 1'b1, LA + 32'h20, NONE, "R5 hit on full table");
    snp(1'b1, LDD, CONF, "R5 existing entry kept");
    discard("R10 discard");

    // release of a read line frees the entry
    loc(LD, 1'b1, LA, NONE, "R6 txn load");
    loc(REL, 1'b0, LA, NONE, "R6 release");
    snp(1'b1, LA, NONE, "R6 released line no conflict");
    loc(LD, 1'b1, LB, NONE, "R6 refill 1");
    loc(LD, 1'b1, LC, NONE, "R6 refill 2");
    loc(LD, 1'b1, LDD, NONE, "R6 refill 3");
    loc(LD, 1'b1, LE, NONE, "R6 freed entry reused");
    discard("R10 discard");

    // release on written line
    loc(ST, 1'b1, LB, NONE, "R7 txn store");
    loc(REL, 1'b0, LB, NONE, "R7 release ignored");
    snp(1'b0, LB, CONF, "R7 tracking kept");
    discard("R10 discard");

    // release with several word positions
    loc(LD, 1'b1, LC, NONE, "R8 word 0");
    loc(LD, 1'b1, LC + 32'h08, NONE, "R8 word 1");
    loc(REL, 1'b0, LC, RELF, "R8 release on two words");
    snp(1'b1, LC, CONF, "R8 tracking kept");
    discard("R10 discard");
    loc(LD, 1'b1, LDD, NONE, "R8 word 0");
    loc(LD, 1'b1, LDD + 32'h04, NONE, "R8 same word again");
    loc(REL, 1'b0, LDD, NONE, "R8 single word release ok");
    snp(1'b1, LDD, NONE, "R8 single word released");
    discard("R10 discard");

    // same-cycle snoop and local update
    step(1'b1, ST, 1'b1, LA, 1'b1, 1'b0, LA, 1'b0, 1'b0, NONE, "R12 snoop before local store");
    snp(1'b0, LA, CONF, "R12 store recorded after");
    discard("R10 discard");

    // commit with a local access in the same cycle
    step(1'b1, LD, 1'b1, LA, 1'b0, 1'b0, '0, 1'b1, 1'b0, NONE, "R10 commit with load");
    snp(1'b1, LA, NONE, "R10 load in commit cycle dropped");

    // transaction closed
    setTxn(1'b0);
    loc(LD, 1'b1, LB, NONE, "R11 load while closed");
    snp(1'b1, LB, NONE, "R11 snoop while closed");
    setTxn(1'b1);
    snp(1'b1, LB, NONE, "R11 closed load not tracked");

    @(posedge clk);
    #2;
    finishRun();
  end

endmodule